// File: doc/BRIEF.md
# Serial Control-Register Target with Deferred Read-Back

This block is a serial-peripheral target that gives a host access to a small bank of 8-bit control registers. The host sends 16-bit words. Each word has its own chip-select low pulse, is sent MSB first, and carries an address byte in the upper half and a data byte in the lower half. The bus runs with the clock idle low and the second clock edge as the sampling edge. The target therefore captures MOSI on the falling SCK edge and drives MISO on the rising edge. All three bus lines are oversampled by a faster system clock through two-flop synchronizers.

Bit 15 of a word selects a write. Bits 14:8 are the register address and bits 7:0 carry the data. A read word uses data bit 7 to choose between two sources: the addressed register's contents, or a 14-bit status word from the surrounding logic. The answer to any word is not returned at once. It is held in a reply register and shifted out during the next chip-select pulse, so a host that wants N answers sends N+1 words. Register 0x00 holds a 2-bit operating-mode field in bits 7:6. Register 0x14 holds the watchdog setting, and a zero there turns the watchdog off.

Top module: `spi_reg_target`

## Requirements
- R1: A word is received MSB first. MOSI is captured on each falling SCK edge, and MISO changes only on rising SCK edges while chip-select is low. Bits 15:8 form the address byte and bits 7:0 form the data byte.
- R2: A word with bit 15 = 1 writes its data byte into the register addressed by bits 14:8.
- R3: A read word (bit 15 = 0) with data bit 7 = 1 returns the addressed register in reply bits 7:0, with reply bits 15:8 at zero.
- R4: A read word with data bit 7 = 0 returns `status_i`, captured at the end of the word, in reply bits 13:0.
- R5: The reply to a word is shifted out during the next chip-select pulse, not during the word itself.
- R6: Reply bits 15:14 are always 0.
- R7: A chip-select pulse that does not hold exactly 16 falling SCK edges is discarded. It writes no register and leaves the pending reply unchanged.
- R8: After reset, every register is 0 except the watchdog register, which holds `WDOG_RESET` (default 0x0F). The first reply after reset is all zeros.
- R9: `mode_o` shows bits 7:6 of register 0x00. `normal_o` is 1 exactly when that field equals 1.
- R10: `wdog_en_o` is 1 while register 0x14 is nonzero. Writing 0 to 0x14 clears it.
- R11: Addresses at or above `NUM_REGS` hold nothing. Writes to them are dropped and control reads of them return 0. The reply to a write is the value written if the address is in range, and 0 otherwise.
- R12: MISO is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip-select, active low, one pulse per word |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| status_i | input | 14 | Status word returned by status reads |
| mode_o | output | 2 | Mode field of register 0x00 |
| normal_o | output | 1 | High when the mode field selects normal operation |
| wdog_en_o | output | 1 | High while the watchdog register is nonzero |

## Verification
The assertions check several rules on every cycle. A word is accepted only after a bit count of exactly 16, the edge counter never runs past its overflow marker, and MISO stays quiet while chip-select is high. They also check that the pending reply holds between accepted words, that an accepted write lands in its register, and that writes to the mode and watchdog registers reach the outputs one cycle later. Other behaviour needs multi-word scenarios and is left to the bench. This covers the one-word lag of every answer, the choice between control and status read-back, the handling of out-of-range addresses, and the discarding of short and overlong pulses together with the stale reply that follows them.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int FRAME_W      = 16;
    localparam int STATUS_W     = 14;
    localparam int ADDR_W       = 7;
    localparam int RD_CTRL_BIT  = 7;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h00;
    localparam logic [ADDR_W-1:0] WDOG_ADDR = 7'h14;
    localparam logic [1:0] MODE_NORMAL = 2'b01;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } frame_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic stage1_q, stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= RST_VAL[b];
                stage2_q <= RST_VAL[b];
            end else begin
                stage1_q <= async_i[b];
                stage2_q <= stage1_q;
            end
        end
        assign sync_o[b] = stage2_q;
    end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               cs_n_s,
    input  logic [FRAME_W-1:0] reply_i,
    output logic               frame_valid_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               miso_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sck_prev;
        logic               cs_prev;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
        logic               miso;
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise;

    always_comb begin
        sck_rise = sck_s & ~st_q.sck_prev;
        sck_fall = ~sck_s & st_q.sck_prev;
        cs_fall  = st_q.cs_prev & ~cs_n_s;
        cs_rise  = ~st_q.cs_prev & cs_n_s;

        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_n_s;

        if (cs_fall) begin
            st_d.tx  = reply_i;
            st_d.rx  = '0;
            st_d.cnt = '0;
        end else if (!cs_n_s) begin
            if (sck_rise) begin
                st_d.miso = st_q.tx[FRAME_W-1];
                st_d.tx   = {st_q.tx[FRAME_W-2:0], 1'b0};
            end
            if (sck_fall) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], mosi_s};
                if (st_q.cnt != CNT_OVER) st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cs_rise) begin
            st_d.valid = (st_q.cnt == CNT_FULL);
            st_d.frame = st_q.rx;
        end

        if (cs_n_s) st_d.miso = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid_o = st_q.valid;
    assign frame_o       = st_q.frame;
    assign miso_o        = st_q.miso;

    // R7: a word is accepted only after exactly 16 captured bits
    a_r7_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(st_q.cnt) == CNT_FULL);
    // R7: overlong pulses saturate the counter at the overflow marker
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_OVER);
    // R12: MISO quiet while chip-select is high
    a_r12_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cs_prev |-> !st_q.miso);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter logic [7:0] WDOG_RESET = 8'h0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid_i,
    input  logic [FRAME_W-1:0]  frame_i,
    input  logic [STATUS_W-1:0] status_i,
    output logic [FRAME_W-1:0]  reply_o,
    output logic [1:0]          mode_o,
    output logic                normal_o,
    output logic                wdog_en_o
);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int WDOG_IDX = int'(WDOG_ADDR);
    localparam int CTRL_IDX = int'(CTRL_ADDR);
    localparam logic [ADDR_W:0] REG_LIMIT = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
        logic [FRAME_W-1:0]       reply;
    } bank_st_t;

    bank_st_t st_d, st_q;
    frame_t   f;
    logic     in_range;
    logic [IDX_W-1:0] idx;

    always_comb begin
        f        = frame_t'(frame_i);
        in_range = {1'b0, f.addr} < REG_LIMIT;
        idx      = f.addr[IDX_W-1:0];

        st_d = st_q;
        if (frame_valid_i) begin
            if (f.wr) begin
                if (in_range) begin
                    st_d.regs[idx] = f.data;
                    st_d.reply     = {8'h00, f.data};
                end else begin
                    st_d.reply = '0;
                end
            end else if (f.data[RD_CTRL_BIT]) begin
                st_d.reply = in_range ? {8'h00, st_q.regs[idx]} : '0;
            end else begin
                st_d.reply = {{(FRAME_W-STATUS_W){1'b0}}, status_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.regs[WDOG_IDX] <= WDOG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign reply_o   = st_q.reply;
    assign mode_o    = st_q.regs[CTRL_IDX][7:6];
    assign normal_o  = (mode_o == MODE_NORMAL);
    assign wdog_en_o = |st_q.regs[WDOG_IDX];

    // R2: an accepted in-range write lands in its register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && frame_i[15] && in_range)
        |=> st_q.regs[$past(idx)] == $past(frame_i[7:0]));
    // R7: the pending reply only moves on an accepted word
    a_r7_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_i |=> $stable(st_q.reply));
    // R10: writing zero to the watchdog register disables it
    a_r10_wdog_off: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && frame_i[15] && frame_i[14:8] == WDOG_ADDR && frame_i[7:0] == 8'h00)
        |=> !wdog_en_o);
    // R9: writing mode 1 selects normal operation
    a_r9_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && frame_i[15] && frame_i[14:8] == CTRL_ADDR && frame_i[7:6] == MODE_NORMAL)
        |=> normal_o);
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
    import spi_regs_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter logic [7:0] WDOG_RESET = 8'h0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [STATUS_W-1:0] status_i,
    output logic [1:0]          mode_o,
    output logic                normal_o,
    output logic                wdog_en_o
);
    logic [2:0]         pins_s;
    logic               frame_valid;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] reply;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sck, spi_cs_n, spi_mosi}),
        .sync_o  (pins_s)
    );

    spi_frame_shifter u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_s         (pins_s[2]),
        .mosi_s        (pins_s[0]),
        .cs_n_s        (pins_s[1]),
        .reply_i       (reply),
        .frame_valid_o (frame_valid),
        .frame_o       (frame),
        .miso_o        (spi_miso)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS), .WDOG_RESET(WDOG_RESET)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (frame_valid),
        .frame_i       (frame),
        .status_i      (status_i),
        .reply_o       (reply),
        .mode_o        (mode_o),
        .normal_o      (normal_o),
        .wdog_en_o     (wdog_en_o)
    );
endmodule

// File: tb/tb_spi_reg_target.sv
module tb_spi_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NVEC       = 13;
    // {word sent, reply expected on MISO during that word}
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        32'h1480_0000,  // R8 first reply zero
        32'h0080_000F,  // R3 watchdog reset value read back
        32'h8040_0000,  // R3 mode reg reset
        32'h9400_0040,  // R2 R11 write reply
        32'h0500_0000,  // R10 write-zero reply
        32'h85A5_1A5C,  // R4 status reply
        32'h0580_00A5,  // R11 write reply
        32'hFF33_00A5,  // R3 read ctrl 5
        32'h7F80_0000,  // R11 out-of-range write reply
        32'h0080_0000,  // R11 out-of-range read
        32'h83FF_0040,  // R3 mode reg read
        32'h0380_00FF,  // R2 write reply
        32'h0000_00FF   // R5 R3 read ctrl 3
    };

    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, mosi = 0;
    logic miso;
    logic [13:0] status = 14'h1A5C;
    logic [1:0] mode;
    logic normal, wdog_en;
    int checks = 0, failures = 0;
    logic [15:0] rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_target dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .status_i(status),
        .mode_o(mode), .normal_o(normal), .wdog_en_o(wdog_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rxo);
        logic [15:0] sh = tx;
        rxo = '0;
        @(negedge clk) cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck  = 1;
            mosi = sh[15];
            sh   = {sh[14:0], 1'b0};
            repeat (HALF) @(negedge clk);
            rxo  = {rxo[14:0], miso};
            sck  = 0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1;
        repeat (4*HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R8 mode reset", {14'h0, mode}, 16'h0000);
        chk("R8 watchdog on at reset", {15'h0, wdog_en}, 16'h0001);
        chk("R9 normal off at reset", {15'h0, normal}, 16'h0000);
        chk("R12 idle miso", {15'h0, miso}, 16'h0000);

        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][31:16], 16, rx);
            chk($sformatf("R1 R5 vector %0d", v), rx, VEC[v][15:0]);
        end
        chk("R9 mode after write", {14'h0, mode}, 16'h0001);
        chk("R9 normal after write", {15'h0, normal}, 16'h0001);
        chk("R10 watchdog cleared", {15'h0, wdog_en}, 16'h0000);

        // R7 short pulse is discarded
        xfer(16'h0080, 16, rx);
        chk("R4 status after table", rx, 16'h1A5C);
        xfer(16'h8080, 12, rx);
        xfer(16'h0080, 16, rx);
        chk("R7 short pulse keeps reply", rx, 16'h0040);
        chk("R7 short pulse no write", {14'h0, mode}, 16'h0001);

        // R7 overlong pulse is discarded
        xfer(16'h9455, 17, rx);
        xfer(16'h1480, 16, rx);
        chk("R7 long pulse keeps reply", rx, 16'h0040);
        xfer(16'h0000, 16, rx);
        chk("R7 long pulse no write", rx, 16'h0000);
        chk("R10 watchdog still off", {15'h0, wdog_en}, 16'h0000);

        // R9 other mode values
        xfer(16'h8080, 16, rx);
        chk("R9 mode two", {14'h0, mode}, 16'h0002);
        chk("R9 normal off for mode two", {15'h0, normal}, 16'h0000);
        xfer(16'h8040, 16, rx);
        chk("R9 normal back on", {15'h0, normal}, 16'h0001);

        // R10 enable then disable
        xfer(16'h9401, 16, rx);
        chk("R10 watchdog on", {15'h0, wdog_en}, 16'h0001);
        xfer(16'h9400, 16, rx);
        chk("R10 watchdog off", {15'h0, wdog_en}, 16'h0000);

        // R6 spare reply bits with an all-ones status
        status = 14'h3FFF;
        xfer(16'h0000, 16, rx);
        xfer(16'h0080, 16, rx);
        chk("R6 R4 all-ones status", rx, 16'h3FFF);
        chk("R12 miso idle after traffic", {15'h0, miso}, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule